// File: doc/BRIEF.md
# Serial Test-Data Output Shifter with Pattern Generator

This block produces the serial test-data stream for a scan controller. In its normal mode the host hands it bytes one at a time, and the bytes are held in a small queue of byte-wide stages. On every test-clock tick issued by the clock controller, the block sends out one bit, least significant bit first. When the buffer has nothing left to send, the block asks the clock controller to hold the test clock. It also reports whether it can accept another byte, and that flag is meant to feed an interrupt request.

The same 32 bits of storage can instead act as a pseudo-random pattern generator. In this mode the host seeds each of the four byte segments by address. The test clock is held until every segment has been seeded. After that, every tick advances a right-shifting linear feedback shift register, and its low bit is the serial output. Any change of mode throws away the queued bytes and the seed state.

Top module: `serial_pattern_out`

## Requirements
- R1: While rstN is low and right after it is released, bufEmpty and notFull are 1 and serOut is 1. stallReq equals enable.
- R2: In queue mode (genMode=0), each write (wrEn=1) stores wrData into the next free stage. A write while both stages are full is dropped, and the queued data is unchanged.
- R3: In queue mode, serOut shows the current bit of the oldest byte, least significant bit first. Each accepted tick moves to the next bit. After its eighth bit, that byte is released and the next byte is presented. A write and a tick in the same cycle are both honoured.
- R4: In queue mode, bufEmpty is 1 when no byte is held, and notFull is 1 when fewer than two bytes are held. serOut is 1 while the queue is empty.
- R5: stallReq is enable AND (queue empty) in queue mode. In generator mode it is enable AND (not all four segments seeded).
- R6: A tick (shiftTick=1) is ignored, with no effect on the serial sequence, when enable is 0, when the queue is empty, or when the generator is not fully seeded.
- R7: In generator mode, a write loads wrData into bits [8*wrAddr+7 : 8*wrAddr] of the 32-bit state and marks that segment seeded. Any change of genMode clears all seeded flags and empties the queue. Writes and ticks in the first cycle after a mode change are ignored.
- R8: In generator mode with all segments seeded, each accepted tick replaces state s with {s[0]^s[10]^s[30]^s[31], s[31:1]}. serOut is s[0].
- R9: In generator mode, a seed write in the same cycle as a tick takes effect, and that tick is dropped.
- R10: In generator mode, both bufEmpty and notFull are 1 exactly when some segment is still unseeded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Enables shifting and stall requests |
| genMode | input | 1 | 1 selects the pattern generator, 0 selects the byte queue |
| wrEn | input | 1 | Host byte write strobe |
| wrAddr | input | 2 | Segment index for seed writes |
| wrData | input | 8 | Host write data |
| shiftTick | input | 1 | One-cycle pulse for each issued test-clock tick |
| serOut | output | 1 | Serial test data |
| bufEmpty | output | 1 | Nothing to send (queue empty, or generator unseeded) |
| notFull | output | 1 | Room for a byte, or seeding still incomplete |
| stallReq | output | 1 | Request to hold the test clock |

## Verification
The bench builds the block with its default parameters: two queue stages over four 8-bit segments, and the tap mask for bits 0, 10, 30 and 31. With two stages, the full-queue drop and a simultaneous write-and-pop are reachable within a handful of cycles. The full 32-bit state width lets a bench-side register model track more than forty generator steps after seeding, after a disabled tick and after a seed write that collides with a tick. Mode toggles are used to show that the seeded flags and the queue are discarded.

// File: rtl/spo_pkg.sv
package spo_pkg;
  parameter int SEG_W = 8;
  parameter int NUM_SEG = 4;
  localparam int SEG_IDX_W = $clog2(NUM_SEG);
  localparam int STATE_W = SEG_W * NUM_SEG;

  typedef struct packed {
    logic [NUM_SEG-1:0]   wrSeg;     // one-hot segment load
    logic [SEG_IDX_W-1:0] headSeg;   // segment holding the oldest queued byte
    logic                 shiftHead; // shift the head segment right by one
    logic                 shiftAll;  // advance the whole register as an LFSR
  } strobes_t;
endpackage

// File: rtl/spo_ctrl.sv
module spo_ctrl
  import spo_pkg::*;
#(
  parameter int FIFO_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     genMode,
  input  logic     wrEn,
  input  logic [SEG_IDX_W-1:0] wrAddr,
  input  logic     shiftTick,
  output strobes_t strobes,
  output logic     fifoEmpty,
  output logic     fifoFull,
  output logic     allSeeded
);
  localparam int PTR_W = (FIFO_STAGES > 1) ? $clog2(FIFO_STAGES) : 1;
  localparam int CNT_W = $clog2(FIFO_STAGES + 1);
  localparam int BIT_W = $clog2(SEG_W);

  logic               genModeQ;
  logic [CNT_W-1:0]   cnt;
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [BIT_W-1:0]   bitCnt;
  logic [NUM_SEG-1:0] segValid;

  logic modeChange, acceptWr, seedWr, fifoShift, genShift, popNow;

  assign modeChange = genMode ^ genModeQ;
  assign fifoEmpty  = (cnt == '0);
  assign fifoFull   = (cnt == CNT_W'(FIFO_STAGES));
  assign allSeeded  = &segValid;

  assign acceptWr  = wrEn & ~genMode & ~fifoFull & ~modeChange;
  assign seedWr    = wrEn & genMode & ~modeChange;
  assign fifoShift = shiftTick & enable & ~genMode & ~fifoEmpty & ~modeChange;
  assign genShift  = shiftTick & enable & genMode & allSeeded & ~seedWr & ~modeChange;
  assign popNow    = fifoShift & (bitCnt == BIT_W'(SEG_W - 1));

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_STAGES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    strobes.shiftHead = fifoShift;
    strobes.shiftAll  = genShift;
    strobes.headSeg   = SEG_IDX_W'(rdPtr);
    for (int i = 0; i < NUM_SEG; i++) begin
      strobes.wrSeg[i] = (acceptWr & (SEG_IDX_W'(wrPtr) == SEG_IDX_W'(i))) |
                         (seedWr & (wrAddr == SEG_IDX_W'(i)));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genModeQ <= 1'b0;
      cnt      <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      bitCnt   <= '0;
      segValid <= '0;
    end else begin
      genModeQ <= genMode;
      if (modeChange) begin
        cnt      <= '0;
        wrPtr    <= '0;
        rdPtr    <= '0;
        bitCnt   <= '0;
        segValid <= '0;
      end else begin
        if (acceptWr) wrPtr <= nextPtr(wrPtr);
        if (popNow) rdPtr <= nextPtr(rdPtr);
        if (fifoShift) bitCnt <= bitCnt + 1'b1;
        case ({acceptWr, popNow})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
        if (seedWr) segValid <= segValid | strobes.wrSeg;
      end
    end
  end
endmodule

// File: rtl/spo_datapath.sv
module spo_datapath
  import spo_pkg::*;
#(
  parameter logic [STATE_W-1:0] TAP_MASK = 32'hC000_0401
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strobes,
  input  logic [SEG_W-1:0] wrData,
  output logic             headBit,
  output logic             lsbBit
);
  logic [SEG_W-1:0]   segQ [NUM_SEG];
  logic [STATE_W-1:0] flat;
  logic [STATE_W-1:0] genNext;
  logic               feedback;

  always_comb begin
    for (int i = 0; i < NUM_SEG; i++) flat[i*SEG_W +: SEG_W] = segQ[i];
  end

  assign feedback = ^(flat & TAP_MASK);
  assign genNext  = {feedback, flat[STATE_W-1:1]};

  for (genvar g = 0; g < NUM_SEG; g++) begin : gSeg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        segQ[g] <= '0;
      end else if (strobes.wrSeg[g]) begin
        segQ[g] <= wrData;
      end else if (strobes.shiftAll) begin
        segQ[g] <= genNext[g*SEG_W +: SEG_W];
      end else if (strobes.shiftHead && strobes.headSeg == SEG_IDX_W'(g)) begin
        segQ[g] <= segQ[g] >> 1;
      end
    end
  end

  assign headBit = segQ[strobes.headSeg][0];
  assign lsbBit  = segQ[0][0];
endmodule

// File: rtl/serial_pattern_out.sv
module serial_pattern_out
  import spo_pkg::*;
#(
  parameter int                 FIFO_STAGES = 2,
  parameter logic [STATE_W-1:0] TAP_MASK    = 32'hC000_0401
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic                 genMode,
  input  logic                 wrEn,
  input  logic [SEG_IDX_W-1:0] wrAddr,
  input  logic [SEG_W-1:0]     wrData,
  input  logic                 shiftTick,
  output logic                 serOut,
  output logic                 bufEmpty,
  output logic                 notFull,
  output logic                 stallReq
);
  strobes_t strobes;
  logic fifoEmpty, fifoFull, allSeeded, headBit, lsbBit;

  spo_ctrl #(.FIFO_STAGES(FIFO_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .genMode(genMode),
    .wrEn(wrEn), .wrAddr(wrAddr), .shiftTick(shiftTick),
    .strobes(strobes), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .allSeeded(allSeeded)
  );

  spo_datapath #(.TAP_MASK(TAP_MASK)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .headBit(headBit), .lsbBit(lsbBit)
  );

  assign serOut   = genMode ? lsbBit : (fifoEmpty | headBit);
  assign bufEmpty = genMode ? ~allSeeded : fifoEmpty;
  assign notFull  = genMode ? ~allSeeded : ~fifoFull;
  assign stallReq = enable & (genMode ? ~allSeeded : fifoEmpty);
endmodule

// File: rtl/spo_checker.sv
module spo_checker (
  input logic clk,
  input logic rstN,
  input logic genMode,
  input logic wrEn,
  input logic shiftTick,
  input logic serOut,
  input logic bufEmpty,
  input logic notFull,
  input logic stallReq
);
  // R4: an empty queue idles high and has room
  p_empty_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!genMode && bufEmpty) |-> (serOut && notFull));

  // R5: a stall request always coincides with room or missing seed
  p_stall_room_r5: assert property (@(posedge clk) disable iff (!rstN)
    stallReq |-> notFull);

  // R6: while stalled and with no write, the serial output does not move
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stallReq && !wrEn && $stable(genMode)) |=>
      ($stable(serOut) || (genMode != $past(genMode))));

  // R2: a full queue without a tick stays full
  p_full_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!genMode && !notFull && !shiftTick && $stable(genMode)) |=>
      (!notFull || genMode));

  // R7: a fully seeded generator stays seeded while the mode holds
  p_seed_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (genMode && !notFull && $stable(genMode)) |=> (!genMode || !notFull));
endmodule

bind serial_pattern_out spo_checker uChk (
  .clk(clk), .rstN(rstN), .genMode(genMode), .wrEn(wrEn),
  .shiftTick(shiftTick), .serOut(serOut), .bufEmpty(bufEmpty),
  .notFull(notFull), .stallReq(stallReq)
);

// File: tb/serial_pattern_out_test.sv
module serial_pattern_out_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1, genMode = 1'b0, wrEn = 1'b0, shiftTick = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic serOut, bufEmpty, notFull, stallReq;

  int checks = 0, errors = 0;
  logic finished = 1'b0;
  logic [31:0] model;

  always #2.5 clk = ~clk;

  serial_pattern_out uut (
    .clk(clk), .rstN(rstN), .enable(enable), .genMode(genMode),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .shiftTick(shiftTick),
    .serOut(serOut), .bufEmpty(bufEmpty), .notFull(notFull), .stallReq(stallReq)
  );

  // {wr, data[7:0], tick, expSer, expEmpty, expNotFull, expStall}
  localparam logic [13:0] VEC [28] = '{
    {1'b1, 8'hA5, 1'b0, 4'b1010}, {1'b1, 8'h3C, 1'b0, 4'b1000},
    {1'b1, 8'hFF, 1'b0, 4'b1000}, {1'b0, 8'h00, 1'b1, 4'b0000},
    {1'b0, 8'h00, 1'b1, 4'b1000}, {1'b0, 8'h00, 1'b1, 4'b0000},
    {1'b0, 8'h00, 1'b1, 4'b0000}, {1'b0, 8'h00, 1'b1, 4'b1000},
    {1'b0, 8'h00, 1'b1, 4'b0000}, {1'b0, 8'h00, 1'b1, 4'b1000},
    {1'b0, 8'h00, 1'b1, 4'b0010}, {1'b1, 8'h81, 1'b1, 4'b0000},
    {1'b0, 8'h00, 1'b1, 4'b1000}, {1'b0, 8'h00, 1'b1, 4'b1000},
    {1'b0, 8'h00, 1'b1, 4'b1000}, {1'b0, 8'h00, 1'b1, 4'b1000},
    {1'b0, 8'h00, 1'b1, 4'b0000}, {1'b0, 8'h00, 1'b1, 4'b0000},
    {1'b0, 8'h00, 1'b1, 4'b1010}, {1'b0, 8'h00, 1'b1, 4'b0010},
    {1'b0, 8'h00, 1'b1, 4'b0010}, {1'b0, 8'h00, 1'b1, 4'b0010},
    {1'b0, 8'h00, 1'b1, 4'b0010}, {1'b0, 8'h00, 1'b1, 4'b0010},
    {1'b0, 8'h00, 1'b1, 4'b0010}, {1'b0, 8'h00, 1'b1, 4'b1010},
    {1'b0, 8'h00, 1'b1, 4'b1111}, {1'b0, 8'h00, 1'b1, 4'b1111}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [1:0] addr, input logic [7:0] data,
                      input logic tick);
    @(negedge clk);
    wrEn = wr; wrAddr = addr; wrData = data; shiftTick = tick;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] lfsrStep(input logic [31:0] s);
    return {s[0] ^ s[10] ^ s[30] ^ s[31], s[31:1]};
  endfunction

  task automatic checkFlags(input string tag, input logic e, input logic nf, input logic st);
    check({tag, " bufEmpty"}, 32'(bufEmpty), 32'(e));
    check({tag, " notFull"}, 32'(notFull), 32'(nf));
    check({tag, " stallReq"}, 32'(stallReq), 32'(st));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset serOut", 32'(serOut), 32'd1);
    checkFlags("R1 reset", 1'b1, 1'b1, 1'b1);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    checkFlags("R1 after release", 1'b1, 1'b1, 1'b1);

    // Queue-mode vectors: R2 drop when full, R3 bit order and hand-over, R4 flags
    foreach (VEC[i]) begin
      step(VEC[i][13], 2'd0, VEC[i][12:5], VEC[i][4]);
      check($sformatf("R3 vec%0d serOut", i), 32'(serOut), 32'(VEC[i][3]));
      check($sformatf("R4 vec%0d bufEmpty", i), 32'(bufEmpty), 32'(VEC[i][2]));
      check($sformatf("R2 vec%0d notFull", i), 32'(notFull), 32'(VEC[i][1]));
      check($sformatf("R5 vec%0d stallReq", i), 32'(stallReq), 32'(VEC[i][0]));
    end

    // R6: disabled ticks in queue mode are ignored; no stall when disabled
    step(1'b1, 2'd0, 8'h02, 1'b0);
    check("R4 byte 02 bit0", 32'(serOut), 32'd0);
    enable = 1'b0;
    step(1'b0, 2'd0, 8'h00, 1'b1);
    check("R6 disabled tick serOut", 32'(serOut), 32'd0);
    check("R5 disabled stall", 32'(stallReq), 32'd0);
    enable = 1'b1;
    step(1'b0, 2'd0, 8'h00, 1'b1);
    check("R3 enabled tick serOut", 32'(serOut), 32'd1);

    // R7: enter generator mode; write in the change cycle is ignored
    genMode = 1'b1;
    step(1'b1, 2'd3, 8'hC0, 1'b0);
    step(1'b1, 2'd0, 8'h34, 1'b0);
    step(1'b1, 2'd1, 8'h12, 1'b0);
    step(1'b1, 2'd2, 8'hDE, 1'b0);
    checkFlags("R7 seg3 write dropped", 1'b1, 1'b1, 1'b1);
    checkFlags("R10 three seeded", 1'b1, 1'b1, 1'b1);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    check("R6 unseeded tick serOut", 32'(serOut), 32'd0);
    step(1'b1, 2'd3, 8'hC0, 1'b0);
    model = 32'hC0DE_1234;
    checkFlags("R10 fully seeded", 1'b0, 1'b0, 1'b0);
    check("R8 seed bit0", 32'(serOut), 32'(model[0]));

    for (int k = 0; k < 40; k++) begin
      step(1'b0, 2'd0, 8'h00, 1'b1);
      model = lfsrStep(model);
      check($sformatf("R8 lfsr step %0d", k), 32'(serOut), 32'(model[0]));
    end

    enable = 1'b0;
    step(1'b0, 2'd0, 8'h00, 1'b1);
    check("R6 gen disabled tick", 32'(serOut), 32'(model[0]));
    enable = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 2'd0, 8'h00, 1'b1);
      model = lfsrStep(model);
      check("R6 gen after disabled tick", 32'(serOut), 32'(model[0]));
    end

    // R9: seed write collides with a tick
    step(1'b1, 2'd0, 8'hFF, 1'b1);
    model[7:0] = 8'hFF;
    check("R9 collide serOut", 32'(serOut), 32'd1);
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 2'd0, 8'h00, 1'b1);
      model = lfsrStep(model);
      check("R9 after collide", 32'(serOut), 32'(model[0]));
    end

    // R7: re-entering clears seeded flags; leaving empties the queue
    genMode = 1'b0;
    step(1'b0, 2'd0, 8'h00, 1'b0);
    genMode = 1'b1;
    step(1'b0, 2'd0, 8'h00, 1'b0);
    step(1'b0, 2'd0, 8'h00, 1'b0);
    checkFlags("R7 reseed needed", 1'b1, 1'b1, 1'b1);
    genMode = 1'b0;
    step(1'b0, 2'd0, 8'h00, 1'b0);
    step(1'b0, 2'd0, 8'h00, 1'b0);
    checkFlags("R7 queue cleared", 1'b1, 1'b1, 1'b1);
    check("R4 cleared serOut", 32'(serOut), 32'd1);

    // R1: reset in the middle of operation
    step(1'b1, 2'd0, 8'h00, 1'b0);
    @(negedge clk); rstN = 1'b0;
    #1;
    check("R1 midrun serOut", 32'(serOut), 32'd1);
    checkFlags("R1 midrun", 1'b1, 1'b1, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule